// File: doc/BRIEF.md
# Handset Watchdog and Transmit-Power Interlock

This block pairs a software watchdog with a hardware power interlock. The watchdog measures elapsed time from the single reference clock. A prescaler turns the reference clock into a slow tick, and a tick counter turns the ticks into the timeout. The processor proves it is alive by writing to one dedicated bus address. If the timeout passes with no such write, the block raises a fixed-length reset pulse. The pulse goes to the on-chip core as an active-high signal and to the board as an active-low pin. When the pulse ends, timing starts over.

The interlock needs no software. Two status lines report whether transmit power and receive power are present. Each line passes through a two-flop synchroniser. If transmit power is seen without receive power for one whole tick period, the active-low power-off output goes low. It stays low until the power-on reset. The external regulators act on that output to cut power to the handset. Neither the watchdog nor the processor can release it.

With the default parameters and an 8.064 MHz clock, the prescaler divides by 8064 to give a 1 kHz tick. The watchdog then expires after 4000 ticks, which is 4 s. The reset pulse lasts 16 clocks.

Top module: `handset_supervisor`

## Requirements
- R1: A restart is a cycle with `bus_wr` high and `bus_addr` equal to `KICK_ADDR`. It clears the watchdog. With no further restart, expiry happens exactly `TIMEOUT_TICKS*TICK_DIV` clocks after the edge that sampled the restart, or after the last edge at which `por` was high.
- R2: A cycle with `bus_wr` low, or with any address other than `KICK_ADDR`, has no effect on the watchdog timing.
- R3: On expiry, `core_rst` goes high and `wdt_rst_n` goes low on the same edge. Both hold for exactly `PULSE_CLKS` clocks.
- R4: When the pulse ends, the watchdog counters start again from zero. The next expiry comes `TIMEOUT_TICKS*TICK_DIV` clocks after the edge that ended the pulse. Restart writes made during the pulse are ignored.
- R5: `tx_pwr` and `rx_pwr` are each synchronised by two flops. The fault condition is transmit present (1) with receive absent (0).
- R6: `pwr_off_n` goes low only after the synchronised fault has held for `TICK_DIV` consecutive clocks. This is `TICK_DIV+2` edges after the raw inputs change. A fault lasting `TICK_DIV-1` clocks or fewer leaves `pwr_off_n` high.
- R7: Once low, `pwr_off_n` stays low until `por`. Restoring receive power, removing transmit power, or a watchdog reset pulse does not release it.
- R8: While `por` is high and after it is released: `core_rst`=0, `wdt_rst_n`=1, `pwr_off_n`=1.
- R9: Transmit and receive both present, or both absent, never drives `pwr_off_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (8.064 MHz by default) |
| por | input | 1 | Power-on reset, active high, synchronous |
| bus_wr | input | 1 | Processor write strobe for the current cycle |
| bus_addr | input | ADDR_W | Processor address for the current cycle |
| tx_pwr | input | 1 | Transmit power present (asynchronous) |
| rx_pwr | input | 1 | Receive power present (asynchronous) |
| core_rst | output | 1 | Watchdog reset to the core, active high |
| wdt_rst_n | output | 1 | Watchdog reset pin, active low |
| pwr_off_n | output | 1 | Latched power-off request, active low |

## Verification
The hardest case to reach is the edge of the timeout window. A restart sampled one clock before the expiry edge must prevent the pulse. A restart sampled one clock after it must be ignored, and the pulse must still run its full length. To reach it, the bench starts each vector from a fresh `por` and counts clock edges exactly, so a single write lands on a chosen edge relative to the expiry.

The other hard case is the glitch limit of the interlock. The bench holds a fault for one clock less than the persistence window and checks that the output does not latch. It then holds the fault without a break and checks the output on the exact edge where it must first read low.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;

    typedef enum logic {
        WD_COUNT = 1'b0,
        WD_PULSE = 1'b1
    } wd_state_t;

    typedef struct packed {
        logic tx;
        logic rx;
    } pwr_sense_t;

    function automatic logic is_fault(input pwr_sense_t s);
        return s.tx && !s.rx;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 8064
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int W = supervisor_pkg::cnt_width(DIV);

    logic [W-1:0] phase;

    assign tick = (phase == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import supervisor_pkg::*;
#(
    parameter int              TICK_DIV      = 8064,
    parameter int              TIMEOUT_TICKS = 4000,
    parameter int              PULSE_CLKS    = 16,
    parameter int              ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] KICK_ADDR   = 16'h3F10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              core_rst,
    output logic              wdt_rst_n
);
    localparam int TW = cnt_width(TIMEOUT_TICKS);
    localparam int PW = cnt_width(PULSE_CLKS);

    wd_state_t     state;
    logic [TW-1:0] ticks;
    logic [PW-1:0] pcnt;
    logic          kick;
    logic          tick;
    logic          presc_clr;

    assign kick      = bus_wr && (bus_addr == KICK_ADDR);
    assign presc_clr = (state == WD_PULSE) || kick;

    tick_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (presc_clr),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WD_COUNT;
            ticks <= '0;
            pcnt  <= '0;
        end else begin
            case (state)
                WD_COUNT: begin
                    if (kick) begin
                        ticks <= '0;
                    end else if (tick) begin
                        if (ticks == TW'(TIMEOUT_TICKS - 1)) begin
                            state <= WD_PULSE;
                            ticks <= '0;
                            pcnt  <= '0;
                        end else begin
                            ticks <= ticks + 1'b1;
                        end
                    end
                end
                WD_PULSE: begin
                    if (pcnt == PW'(PULSE_CLKS - 1)) begin
                        state <= WD_COUNT;
                        ticks <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: state <= WD_COUNT;
            endcase
        end
    end

    assign core_rst  = (state == WD_PULSE);
    assign wdt_rst_n = (state != WD_PULSE);

    assert_kick_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (kick && state == WD_COUNT) |=> (ticks == '0 && state == WD_COUNT));

    // R2: without a restart or a tick the count must not move
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (state == WD_COUNT && !kick && !tick) |=> ($stable(ticks) && state == WD_COUNT));

    assert_expire_at_limit_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> ($past(tick) && $past(ticks) == TW'(TIMEOUT_TICKS - 1)));

    assert_restart_after_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (ticks == '0 && $past(pcnt) == PW'(PULSE_CLKS - 1)));

endmodule

// File: rtl/pwr_interlock.sv
module pwr_interlock
    import supervisor_pkg::*;
#(
    parameter int TICK_DIV = 8064
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_raw,
    input  logic rx_raw,
    output logic pwr_off_n
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] meta;
    logic [NCH-1:0] sync;
    pwr_sense_t     sense;
    logic           fault;
    logic           held;
    logic           off_q;

    assign raw_in = {tx_raw, rx_raw};

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                sync[i] <= 1'b0;
            end else begin
                meta[i] <= raw_in[i];
                sync[i] <= meta[i];
            end
        end
    end

    assign sense = pwr_sense_t'(sync);
    assign fault = is_fault(sense);

    tick_prescaler #(.DIV(TICK_DIV)) u_persist (
        .clk  (clk),
        .rst  (rst),
        .clr  (!fault),
        .tick (held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= 1'b0;
        end else if (fault && held) begin
            off_q <= 1'b1;
        end
    end

    assign pwr_off_n = !off_q;

    assert_off_needs_fault_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(off_q) |-> ($past(fault) && $past(sync) == 2'b10));

    assert_off_persists_R7: assert property (@(posedge clk) disable iff (rst)
        off_q |=> off_q);

    // R9: matching power states never start the latch
    assert_no_off_when_matched_R9: assert property (@(posedge clk) disable iff (rst)
        (!off_q && sync[1] == sync[0]) |=> !off_q);

endmodule

// File: rtl/handset_supervisor.sv
module handset_supervisor #(
    parameter int                TICK_DIV      = 8064,
    parameter int                TIMEOUT_TICKS = 4000,
    parameter int                PULSE_CLKS    = 16,
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] KICK_ADDR     = 16'h3F10
) (
    input  logic              clk,
    input  logic              por,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              tx_pwr,
    input  logic              rx_pwr,
    output logic              core_rst,
    output logic              wdt_rst_n,
    output logic              pwr_off_n
);

    wdog_core #(
        .TICK_DIV      (TICK_DIV),
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .PULSE_CLKS    (PULSE_CLKS),
        .ADDR_W        (ADDR_W),
        .KICK_ADDR     (KICK_ADDR)
    ) u_wdog (
        .clk       (clk),
        .rst       (por),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .core_rst  (core_rst),
        .wdt_rst_n (wdt_rst_n)
    );

    pwr_interlock #(
        .TICK_DIV (TICK_DIV)
    ) u_lock (
        .clk       (clk),
        .rst       (por),
        .tx_raw    (tx_pwr),
        .rx_raw    (rx_pwr),
        .pwr_off_n (pwr_off_n)
    );

    assert_pins_track_R3: assert property (@(posedge clk) disable iff (por)
        core_rst != wdt_rst_n);

endmodule

// File: tb/handset_supervisor_test.sv
module handset_supervisor_test;

    localparam int              CLK_PERIOD = 10;
    localparam int              DIV        = 8;
    localparam int              TMO        = 20;
    localparam int              PW         = 16;
    localparam int              AW         = 16;
    localparam logic [AW-1:0]   KADDR      = 16'h3F10;
    localparam int              TD         = DIV * TMO;

    // restart-window vectors: access type, address, edge offset after por, reset expected at TD+2
    localparam int              VN = 6;
    localparam logic            VEC_WR  [VN] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [AW-1:0]   VEC_ADR [VN] = '{KADDR, KADDR, 16'h3F11, 16'h0F10, KADDR, KADDR};
    localparam int              VEC_DLY [VN] = '{100, 100, 100, 100, TD - 1, TD + 1};
    localparam logic            VEC_EXP [VN] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam string           VEC_REQ [VN] = '{"R1", "R2", "R2", "R2", "R1", "R4"};

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          tx_pwr = 1'b0;
    logic          rx_pwr = 1'b0;
    logic          core_rst;
    logic          wdt_rst_n;
    logic          pwr_off_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    handset_supervisor #(
        .TICK_DIV      (DIV),
        .TIMEOUT_TICKS (TMO),
        .PULSE_CLKS    (PW),
        .ADDR_W        (AW),
        .KICK_ADDR     (KADDR)
    ) uut (
        .clk       (clk),
        .por       (por),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .tx_pwr    (tx_pwr),
        .rx_pwr    (rx_pwr),
        .core_rst  (core_rst),
        .wdt_rst_n (wdt_rst_n),
        .pwr_off_n (pwr_off_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rst(input string req, input string what, input logic exp);
        chk(req, {what, " core_rst"}, int'(core_rst), int'(exp));
        chk(req, {what, " wdt_rst_n"}, int'(wdt_rst_n), int'(!exp));
    endtask

    // leaves the bench at a falling edge; the preceding rising edge is the last with por high
    task automatic do_por();
        @(negedge clk);
        por = 1'b1;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        por = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        wait_edges(2);
        chk_rst("R8", "during por", 1'b0);
        chk("R8", "pwr_off_n during por", int'(pwr_off_n), 1);
        do_por();
        chk_rst("R8", "after por", 1'b0);
        chk("R8", "pwr_off_n after por", int'(pwr_off_n), 1);

        // vector table: restart window
        for (int v = 0; v < VN; v++) begin
            do_por();
            wait_edges(VEC_DLY[v] - 1);
            bus_wr   = VEC_WR[v];
            bus_addr = VEC_ADR[v];
            wait_edges(1);
            bus_wr   = 1'b0;
            bus_addr = '0;
            wait_edges(TD + 2 - VEC_DLY[v]);
            chk_rst(VEC_REQ[v], $sformatf("vector %0d", v), VEC_EXP[v]);
        end

        // R1/R3/R4: exact expiry and pulse length with no restarts
        do_por();
        wait_edges(TD - 1);
        chk_rst("R1", "one edge before expiry", 1'b0);
        wait_edges(1);
        chk_rst("R3", "on expiry edge", 1'b1);
        wait_edges(PW - 1);
        chk_rst("R3", "last pulse clock", 1'b1);
        wait_edges(1);
        chk_rst("R3", "after pulse", 1'b0);
        wait_edges(TD - 1);
        chk_rst("R4", "before second expiry", 1'b0);
        wait_edges(1);
        chk_rst("R4", "second expiry", 1'b1);

        // R4: restart write inside the pulse does not shorten or cancel it
        bus_wr = 1'b1;
        bus_addr = KADDR;
        wait_edges(1);
        bus_wr = 1'b0;
        wait_edges(PW - 3);
        chk_rst("R4", "pulse with write inside", 1'b1);
        wait_edges(2);
        chk_rst("R4", "pulse ends on time", 1'b0);

        // R9: matched power states
        do_por();
        tx_pwr = 1'b1; rx_pwr = 1'b1;
        wait_edges(4 * DIV);
        chk("R9", "both present", int'(pwr_off_n), 1);
        tx_pwr = 1'b0; rx_pwr = 1'b0;
        wait_edges(4 * DIV);
        chk("R9", "both absent", int'(pwr_off_n), 1);

        // R6: glitch one clock shorter than the window
        tx_pwr = 1'b1; rx_pwr = 1'b0;
        wait_edges(DIV - 1);
        tx_pwr = 1'b0;
        wait_edges(4 * DIV);
        chk("R6", "short fault ignored", int'(pwr_off_n), 1);

        // R5/R6: sustained fault, exact latch edge
        tx_pwr = 1'b1; rx_pwr = 1'b0;
        wait_edges(DIV + 1);
        chk("R6", "one edge before latch", int'(pwr_off_n), 1);
        wait_edges(1);
        chk("R5", "latch after sync and window", int'(pwr_off_n), 0);

        // R7: no release by restoring power or by a watchdog pulse
        rx_pwr = 1'b1; tx_pwr = 1'b0;
        wait_edges(4 * DIV);
        chk("R7", "rx restored", int'(pwr_off_n), 0);
        wait_edges(TD + 4);
        chk("R7", "after watchdog pulse", int'(pwr_off_n), 0);
        do_por();
        chk("R7", "released by por", int'(pwr_off_n), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule